// File: doc/BRIEF.md
# Strobed Nibble I/O Port Sequencer

This block sits between a field-bus protocol engine and a small digital port of four output lines and four input lines. When the protocol side hands over a new 4-bit output word, the sequencer stores it in an output register, drives it onto the output lines, and announces it with a timed strobe pulse. A fixed number of cycles after the write, it samples the four input lines through a two-stage synchronizer and returns the captured nibble with a one-cycle valid pulse. That pulse is the done handshake.

The output lines behave as open-drain drivers. They are modelled as a data vector plus a per-bit enable vector. A per-sequence mode flag selects multiplexed bidirectional operation. In that mode the enables are withdrawn for a guard interval before the strobe, through the whole strobe, and for a guard interval after it. This lets externally joined output and input lines carry input data. In the plain mode the outputs stay driven and constant across the strobe. A write that arrives while a sequence runs is refused with a busy indication. It is not queued and it does not restart the timing.

Cycle counts used below are the defaults: guard G = 5, strobe S = 55, sample point T = 122. Cycle 0 is the first cycle after the clock edge that accepts a write. With a 10 MHz clock this gives a 5.5 µs strobe, 0.5 µs guards and input sampling at about 12.2 µs.

Top module: `nibble_port_seq`

## Requirements
- R1: After reset, busy, strobe, in_valid, pin_out, pin_oe and in_data are all zero.
- R2: A write is accepted on a clock edge where wr_req is 1 and busy is 0. From cycle 0 onward, pin_out equals the accepted wr_data.
- R3: busy is 1 in cycles 0 through T and 0 in cycle T+1. While busy is 1, wr_req has no effect: pin_out stays unchanged and the strobe, enable and sampling timing continue as if no request had been made.
- R4: strobe is 1 in exactly cycles 2G through 2G+S-1, which is S cycles, and 0 at every other time.
- R5: In multiplexed mode (mux_mode = 1 at accept), pin_oe is 4'b0000 in cycles G through 3G+S-1. This covers G cycles before the strobe rises, the strobe itself, and G cycles after it falls. In every other cycle after the first accepted write, pin_oe is 4'b1111.
- R6: In plain mode (mux_mode = 0 at accept), pin_oe is 4'b1111 and pin_out is constant in every cycle of the sequence.
- R7: mux_mode is sampled only on the accepting edge. Changing it during a sequence does not alter that sequence's enable pattern.
- R8: in_data takes the value pin_in had during cycle T-2, which is the value seen through a two-flop synchronizer at the end of cycle T. in_valid is 1 for exactly one cycle, cycle T+1. in_data holds its value until the next capture, whatever pin_in does.
- R9: In the in_valid cycle busy is already 0, so a write requested in that cycle is accepted and starts a new sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Request to write a new output word |
| wr_data | input | 4 | Output word to write |
| mux_mode | input | 1 | 1 selects multiplexed bidirectional mode for the next sequence |
| busy | output | 1 | A sequence is running; requests are refused |
| pin_out | output | 4 | Output line data |
| pin_oe | output | 4 | Per-bit output enable; 0 means high impedance |
| strobe | output | 1 | Pulse announcing new output data |
| pin_in | input | 4 | Asynchronous input lines |
| in_data | output | 4 | Captured input nibble |
| in_valid | output | 1 | One-cycle pulse when in_data has just been updated |

## Verification
The hardest situations to produce are a refused write during a running sequence that also flips the mode flag, and an input change sitting right at the synchronizer's capture boundary. The stimulus raises wr_req with fresh random data and an inverted mode flag at random cycles inside each sequence. The expected output is still the original word with the originally latched enable pattern. For the boundary, a directed sequence changes pin_in in cycle T-2 and again in cycle T-1 and expects the earlier value. Another directed case issues a write in the in_valid cycle to show that back-to-back sequences are accepted.

// File: rtl/nps_pkg.sv
package nps_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_PRE    = 3'd2,
      PH_STROBE = 3'd3,
      PH_POST   = 3'd4,
      PH_WAIT   = 3'd5
   } nps_phase_e;

   // Phase of a running sequence from its cycle index.
   function automatic nps_phase_e phase_of(input int unsigned idx,
                                           input int unsigned guard,
                                           input int unsigned width);
      nps_phase_e ph;
      if (idx < guard)                    ph = PH_SETUP;
      else if (idx < 2*guard)             ph = PH_PRE;
      else if (idx < 2*guard + width)     ph = PH_STROBE;
      else if (idx < 3*guard + width)     ph = PH_POST;
      else                                ph = PH_WAIT;
      return ph;
   endfunction

   function automatic logic is_released(input nps_phase_e ph);
      return (ph == PH_PRE) || (ph == PH_STROBE) || (ph == PH_POST);
   endfunction

endpackage

// File: rtl/nps_timer.sv
module nps_timer
   import nps_pkg::*;
#(
   parameter int unsigned GUARD_CYC  = 5,
   parameter int unsigned STROBE_CYC = 55,
   parameter int unsigned SAMPLE_CYC = 122
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_req,
   input  logic       mux_in,
   output logic       accept,
   output logic       busy,
   output logic       mux_lat,
   output nps_phase_e phase,
   output logic       capture
);

   localparam int unsigned CNT_W = $clog2(SAMPLE_CYC + 2);
   localparam int unsigned LAST  = SAMPLE_CYC;

   if (SAMPLE_CYC <= 3*GUARD_CYC + STROBE_CYC) begin : g_bad_window
      $error("sample point must follow the post-strobe guard");
   end
   if (STROBE_CYC == 0) begin : g_bad_strobe
      $error("strobe width must be non-zero");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             mux_q;

   assign accept  = start_req && !busy_q;
   assign busy    = busy_q;
   assign mux_lat = mux_q;
   assign capture = busy_q && (cnt_q == CNT_W'(LAST));

   always_comb begin
      if (busy_q) phase = phase_of(int'(cnt_q), GUARD_CYC, STROBE_CYC);
      else        phase = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         mux_q  <= 1'b0;
      end else if (accept) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
         mux_q  <= mux_in;
      end else if (capture) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // Run length of the strobe phase, checked at its end.
   logic [CNT_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run_q <= '0;
      else if (phase == PH_STROBE) run_q <= run_q + 1'b1;
      else                         run_q <= '0;
   end

   p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_STROBE && run_q != '0) |-> run_q == CNT_W'(STROBE_CYC));

   p_mode_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !accept) |=> $stable(mux_q));

   p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !capture) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

   p_capture_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !busy_q);

endmodule

// File: rtl/nps_out_stage.sv
module nps_out_stage
   import nps_pkg::*;
#(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mux_lat,
   input  nps_phase_e        phase,
   input  logic              busy,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe
);

   if (DATA_W == 0) begin : g_bad_width
      $error("data width must be non-zero");
   end

   logic loaded_q;
   logic release_now;

   assign release_now = mux_lat && is_released(phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      loaded_q <= 1'b0;
      else if (accept) loaded_q <= 1'b1;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dat_q <= 1'b0;
         else if (accept) dat_q <= wr_data[b];
      end
      assign pin_out[b] = dat_q;
      assign pin_oe[b]  = loaded_q && !release_now;
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> pin_out == $past(wr_data));

   p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(pin_out));

   p_mux_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_lat && phase == PH_STROBE) |-> pin_oe == '0);

   p_plain_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mux_lat) |-> pin_oe == '1);

endmodule

// File: rtl/nps_in_capture.sv
module nps_in_capture #(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pin_in,
   input  logic              capture,
   output logic [DATA_W-1:0] in_data,
   output logic              in_valid
);

   logic [DATA_W-1:0] synced;

   for (genvar b = 0; b < DATA_W; b++) begin : g_sync
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced[b] = pin_in[b];
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (SYNC_STAGES == 1) chain_q <= pin_in[b];
            else chain_q <= {chain_q[SYNC_STAGES-2:0], pin_in[b]};
         end
         assign synced[b] = chain_q[SYNC_STAGES-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_data  <= '0;
         in_valid <= 1'b0;
      end else begin
         in_valid <= capture;
         if (capture) in_data <= synced;
      end
   end

   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> !in_valid);

   p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(in_data));

endmodule

// File: rtl/nibble_port_seq.sv
module nibble_port_seq
   import nps_pkg::*;
#(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned GUARD_CYC   = 5,
   parameter int unsigned STROBE_CYC  = 55,
   parameter int unsigned SAMPLE_CYC  = 122,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mux_mode,
   output logic              busy,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe,
   output logic              strobe,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] in_data,
   output logic              in_valid
);

   logic       accept;
   logic       mux_lat;
   logic       capture;
   nps_phase_e phase;

   nps_timer #(
      .GUARD_CYC  (GUARD_CYC),
      .STROBE_CYC (STROBE_CYC),
      .SAMPLE_CYC (SAMPLE_CYC)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (wr_req),
      .mux_in    (mux_mode),
      .accept    (accept),
      .busy      (busy),
      .mux_lat   (mux_lat),
      .phase     (phase),
      .capture   (capture)
   );

   nps_out_stage #(
      .DATA_W (DATA_W)
   ) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .wr_data (wr_data),
      .mux_lat (mux_lat),
      .phase   (phase),
      .busy    (busy),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   nps_in_capture #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .capture  (capture),
      .in_data  (in_data),
      .in_valid (in_valid)
   );

   assign strobe = (phase == PH_STROBE);

   p_guard_before_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(strobe) && mux_lat) |-> $past(pin_oe) == '0);

   p_guard_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(strobe) && mux_lat) |-> pin_oe == '0);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !strobe);

   p_valid_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !busy);

endmodule

// File: tb/test_nibble_port_seq.sv
module test_nibble_port_seq;

   localparam int W = 4;
   localparam int G = 5;
   localparam int S = 55;
   localparam int T = 122;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_req = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         mux_mode = 1'b0;
   logic         busy;
   logic [W-1:0] pin_out;
   logic [W-1:0] pin_oe;
   logic         strobe;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] in_data;
   logic         in_valid;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   nibble_port_seq #(.DATA_W(W), .GUARD_CYC(G), .STROBE_CYC(S),
                     .SAMPLE_CYC(T), .SYNC_STAGES(2)) i_nibble_port_seq (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
      .mux_mode(mux_mode), .busy(busy), .pin_out(pin_out), .pin_oe(pin_oe),
      .strobe(strobe), .pin_in(pin_in), .in_data(in_data), .in_valid(in_valid)
   );

   function automatic bit exp_strobe(int t);
      return (t >= 2*G) && (t < 2*G + S);
   endfunction

   function automatic logic [W-1:0] exp_oe(int t, bit mux);
      if (mux && t >= G && t < 3*G + S) return '0;
      return '1;
   endfunction

   function automatic bit exp_busy(int t);
      return t <= T;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // Runs one sequence. Entered at a negedge, returns at the negedge of cycle T+1.
   // mode: 0 random, 1 boundary on pin_in, 2 no disturbance
   task automatic run_seq(logic [W-1:0] data, bit mux, int mode);
      logic [W-1:0] exp_in = '0;
      bit bad_out = 0, bad_busy = 0, bad_stb = 0, bad_oe = 0, bad_vld = 0;
      int a_out = 0, a_busy = 0, a_stb = 0, a_oe = 0, a_vld = 0;
      int e_busy = 0, e_stb = 0, e_oe = 0;
      bit disturbed = 0;
      wr_req = 1'b1; wr_data = data; mux_mode = mux;
      @(posedge clk);
      for (int t = 0; t <= T + 1; t++) begin
         @(negedge clk);
         wr_req = 1'b0;
         mux_mode = mux;
         if (pin_out !== data && !bad_out) begin bad_out = 1; a_out = pin_out; end
         if (busy !== exp_busy(t) && !bad_busy) begin
            bad_busy = 1; a_busy = t; e_busy = exp_busy(t); end
         if (strobe !== exp_strobe(t) && !bad_stb) begin
            bad_stb = 1; a_stb = t; e_stb = exp_strobe(t); end
         if (pin_oe !== exp_oe(t, mux) && !bad_oe) begin
            bad_oe = 1; a_oe = pin_oe; e_oe = exp_oe(t, mux); end
         if (in_valid !== (t == T + 1) && !bad_vld) begin bad_vld = 1; a_vld = t; end
         // input stimulus: value during cycle T-2 is the one captured
         if (mode == 1 && t == T - 2) pin_in = ~data;
         else if (mode == 1 && t == T - 1) pin_in = data;
         else if (t <= T && ($urandom % 4) == 0) pin_in = W'($urandom);
         if (t == T - 2) exp_in = pin_in;
         // refused write with inverted mode flag
         if (mode == 0 && t < T && ($urandom % 16) == 0) begin
            wr_req = 1'b1; wr_data = ~data; mux_mode = ~mux; disturbed = 1;
         end
      end
      chk(!bad_out, "R2", "pin_out", a_out, data);
      chk(!bad_busy, "R3", "busy at cycle", a_busy, e_busy);
      chk(!bad_stb, "R4", "strobe at cycle", a_stb, e_stb);
      if (mux) chk(!bad_oe, "R5", "pin_oe mux", a_oe, e_oe);
      else     chk(!bad_oe, "R6", "pin_oe plain", a_oe, e_oe);
      if (disturbed) chk(!bad_oe && !bad_out, "R7", "mode held under refused write", a_oe, e_oe);
      chk(in_data === exp_in, "R8", "in_data", in_data, exp_in);
      chk(!bad_vld, "R8", "in_valid pulse at cycle", a_vld, T + 1);
      chk(busy === 1'b0, "R9", "busy in valid cycle", busy, 0);
   endtask

   task automatic hold_check();
      logic [W-1:0] keep = in_data;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         pin_in = ~pin_in;
      end
      chk(in_data === keep && in_valid === 1'b0, "R8", "in_data hold", in_data, keep);
   endtask

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      chk(busy === 0 && strobe === 0 && in_valid === 0, "R1", "ctrl reset",
          {busy, strobe, in_valid}, 0);
      chk(pin_out === '0 && pin_oe === '0 && in_data === '0, "R1", "data reset",
          {pin_out, pin_oe, in_data}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed: plain, multiplexed, boundary capture
      run_seq(4'hA, 1'b0, 2); hold_check();
      run_seq(4'h5, 1'b1, 2); hold_check();
      run_seq(4'h3, 1'b1, 1); hold_check();
      // directed: back-to-back, write in the in_valid cycle (R9)
      run_seq(4'hC, 1'b0, 1);
      run_seq(4'h9, 1'b1, 0); hold_check();
      // random sequences
      for (int n = 0; n < 24; n++) begin
         run_seq(W'($urandom), 1'($urandom), 0);
         if (($urandom % 3) != 0) hold_check();
      end
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
   end

endmodule